// File: doc/BRIEF.md
# Exception Vector Address Remapper

This block sits between the CPU address bus and the memory decoders. The lowest 64 bytes of the byte-addressed space, `0x00000000` to `0x0000003F`, hold the exception vectors. The block can send accesses to that window to one of three physical regions, and it keeps the byte offset inside the window unchanged. Addresses outside the window leave the block unchanged. Translation is combinational, so the physical address and its valid strobe appear in the same cycle as the CPU address.

A 2-bit mapping register selects the target region, and software can rewrite it at any time through a small write/read port. The register is the block's only state, and each of its four codes is treated as a named state:

- `MAP_ONCHIP` (code 00) maps the window straight onto on-chip flash at base `0x00000000`. This is the reset state.
- `MAP_RAM` (code 01) redirects the window to internal RAM at base `0x40000000`.
- `MAP_XFLASH` (code 10) redirects the window to external flash at base `0x80000000`.
- `MAP_RSVD` (code 11) keeps the stored code but translates the same way as `MAP_ONCHIP`.

The transition rule is simple. A cycle with `cfg_we` high moves the register to the state whose code is on `cfg_wdata`, and any state can follow any other. A cycle with `cfg_we` low keeps the current state.

Top module: `vec_remap`

## Requirements
- R1: Reset leaves the mapping register at code 00 (`cfg_rdata` = 0), so address 0x00000000 comes out as 0x00000000.
- R2: `cfg_rdata` returns the code last written, including the reserved code 11, from the cycle after the write.
- R3: With code 01, a window address A (0x00..0x3F) comes out as 0x40000000 | A[5:0].
- R4: With code 10, a window address A comes out as 0x80000000 | A[5:0].
- R5: With code 00 or the reserved code 11, a window address comes out unchanged.
- R6: In every mode, an address with any of bits [31:6] set comes out unchanged.
- R7: A write changes the translation only from the cycle after `cfg_we` is high. An access in the cycle of the write still uses the old mapping.
- R8: `phys_valid` equals `cpu_valid` in the same cycle.
- R9: While `cfg_we` is low, the mapping register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 32 | Byte address from the CPU |
| cpu_valid | input | 1 | CPU address is valid |
| cfg_we | input | 1 | Write strobe for the mapping register |
| cfg_wdata | input | 2 | Mapping code to write |
| cfg_rdata | output | 2 | Stored mapping code |
| phys_addr | output | 32 | Translated physical address |
| phys_valid | output | 1 | Physical address is valid |

## Verification
The bench writes each of the four codes in turn. For each code it sweeps all 64 window offsets, and it also probes addresses just outside the window and addresses inside the target regions themselves.

- A window detector with an off-by-one boundary would alter `0x40` or leave `0x3F` unchanged.
- A base substitution that drops the offset would send every vector to the base address.
- A decode that gives the reserved code a target of its own would move the window when code 11 is stored.
- A register that is bypassed combinationally would translate the access issued in the write cycle itself with the new mapping.

// File: rtl/vec_remap_pkg.sv
package vec_remap_pkg;

    typedef enum logic [1:0] {
        MAP_ONCHIP = 2'b00,
        MAP_RAM    = 2'b01,
        MAP_XFLASH = 2'b10,
        MAP_RSVD   = 2'b11
    } map_mode_e;

endpackage

// File: rtl/vec_remap_ctrl.sv
module vec_remap_ctrl
    import vec_remap_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RAM_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] XFL_BASE = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        wdata,
    output logic [1:0]        rdata,
    output logic [ADDR_W-1:0] win_base
);

    map_mode_e state_q;

    // state register: a write moves to the coded state, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= MAP_ONCHIP;
        else if (we)
            state_q <= map_mode_e'(wdata);
    end

    // outputs: stored code and the base address for the vector window
    always_comb begin
        rdata = state_q;
        unique case (state_q)
            MAP_ONCHIP: win_base = '0;
            MAP_RAM:    win_base = RAM_BASE;
            MAP_XFLASH: win_base = XFL_BASE;
            MAP_RSVD:   win_base = '0;
        endcase
    end

    AST_RESET_ONCHIP: assert property (@(posedge clk)
        !rst_n |=> state_q == MAP_ONCHIP); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(state_q)); // R9

endmodule

// File: rtl/vec_remap_xlate.sv
module vec_remap_xlate #(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 6
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [ADDR_W-1:0] win_base,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int HI_W = ADDR_W - WIN_BITS;

    logic in_window;
    logic [ADDR_W-1:0] offset_ext;

    always_comb begin
        in_window  = (addr_in[ADDR_W-1:WIN_BITS] == {HI_W{1'b0}});
        offset_ext = {{HI_W{1'b0}}, addr_in[WIN_BITS-1:0]};
        addr_out   = in_window ? (win_base | offset_ext) : addr_in;
    end

endmodule

// File: rtl/vec_remap.sv
module vec_remap
    import vec_remap_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                WIN_BITS = 6,
    parameter logic [ADDR_W-1:0] RAM_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] XFL_BASE = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_valid,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_wdata,
    output logic [1:0]        cfg_rdata,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              phys_valid
);

    logic [ADDR_W-1:0] win_base;

    vec_remap_ctrl #(
        .ADDR_W  (ADDR_W),
        .RAM_BASE(RAM_BASE),
        .XFL_BASE(XFL_BASE)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .win_base(win_base)
    );

    vec_remap_xlate #(
        .ADDR_W  (ADDR_W),
        .WIN_BITS(WIN_BITS)
    ) u_xlate (
        .addr_in (cpu_addr),
        .win_base(win_base),
        .addr_out(phys_addr)
    );

    assign phys_valid = cpu_valid;

    AST_VALID_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        phys_valid == cpu_valid); // R8

    AST_OUTSIDE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (|cpu_addr[ADDR_W-1:WIN_BITS]) |-> phys_addr == cpu_addr); // R6

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[WIN_BITS-1:0] == cpu_addr[WIN_BITS-1:0]); // R3

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == $past(cfg_wdata)); // R2

    AST_IDLE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata)); // R9

endmodule

// File: tb/test_vec_remap.sv
`timescale 1ns/1ps
module test_vec_remap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_valid = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_wdata = '0;
    logic [1:0]  cfg_rdata;
    logic [31:0] phys_addr;
    logic        phys_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    vec_remap i_vec_remap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_valid (cpu_valid),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .phys_addr (phys_addr),
        .phys_valid(phys_valid)
    );

    function automatic logic [31:0] expect_addr(input logic [1:0] m, input logic [31:0] a);
        if (a[31:6] != 26'd0) return a;
        case (m)
            2'b01:   return 32'h4000_0000 | {26'd0, a[5:0]};
            2'b10:   return 32'h8000_0000 | {26'd0, a[5:0]};
            default: return a;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = m;
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata == m, "R2 readback", {30'd0, cfg_rdata}, {30'd0, m});
    endtask

    task automatic probe(input logic [1:0] m, input logic [31:0] a, input string tag);
        logic [31:0] e;
        cpu_addr = a;
        cpu_valid = a[0];
        #1;
        e = expect_addr(m, a);
        check(phys_addr == e, tag, phys_addr, e);
        check(phys_valid == cpu_valid, "R8 valid", {31'd0, phys_valid}, {31'd0, cpu_valid});
    endtask

    initial begin
        logic [31:0] outside [8];
        outside[0] = 32'h0000_0040; outside[1] = 32'h0000_007F;
        outside[2] = 32'h0000_1000; outside[3] = 32'h4000_0000;
        outside[4] = 32'h4000_003F; outside[5] = 32'h8000_0000;
        outside[6] = 32'hFFFF_FFFF; outside[7] = 32'h8000_0004;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_rdata == 2'b00, "R1 reset code", {30'd0, cfg_rdata}, 32'd0);
        probe(2'b00, 32'h0, "R1 reset vector");

        for (int m = 0; m < 4; m++) begin
            write_mode(m[1:0]);
            for (int off = 0; off < 64; off++) begin
                @(negedge clk);
                case (m)
                    1:       probe(m[1:0], off, "R3 ram window");
                    2:       probe(m[1:0], off, "R4 xflash window");
                    default: probe(m[1:0], off, "R5 identity window");
                endcase
            end
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                probe(m[1:0], outside[k], "R6 outside window");
            end
            // R9: idle cycles keep the code
            repeat (3) @(negedge clk);
            check(cfg_rdata == m[1:0], "R9 hold", {30'd0, cfg_rdata}, m);
        end

        // R7: write in same cycle as an access to the window
        write_mode(2'b00);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = 2'b01;
        cpu_addr = 32'h0000_0008;
        #1;
        check(phys_addr == 32'h0000_0008, "R7 old mapping in write cycle", phys_addr, 32'h8);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check(phys_addr == 32'h4000_0008, "R7 new mapping next cycle", phys_addr, 32'h4000_0008);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = 2'b10;
        cpu_addr = 32'h0000_003C;
        #1;
        check(phys_addr == 32'h4000_003C, "R7 old ram mapping", phys_addr, 32'h4000_003C);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check(phys_addr == 32'h8000_003C, "R7 new xflash mapping", phys_addr, 32'h8000_003C);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule